// File: doc/BRIEF.md
# Random Early Drop Decision Unit

This block sits beside an output queue and decides, for every packet that arrives, whether the packet is admitted or discarded. It does not look at the instantaneous queue length directly. Instead it keeps a smoothed running level of queue occupancy, with fractional bits, that moves a programmable fraction of the way toward the sampled length on each arrival. The decision then follows that smoothed level, so short bursts pass without drops while sustained congestion is trimmed early.

Two thresholds divide the smoothed level into three zones. Below the lower threshold everything passes. Above the upper threshold everything is discarded. Between them the drop probability rises linearly from zero to one, and a 16-bit pseudo-random sequence decides each packet on its own. Every flow therefore sees the same odds, which prevents lock-out and synchronised back-off. The divide by the threshold span is replaced by a multiply with a reciprocal that software loads. A misprogrammed pair of thresholds degrades to plain tail dropping.

Top module: `red_drop_unit`

## Requirements
- R1: After reset `dec_valid` and `dec_drop` are 0, the smoothed level is 0 and the random sequence holds the seed 16'hACE1.
- R2: For every cycle in which `arr_valid` is 1, `dec_valid` is 1 for exactly one cycle two cycles later, carrying that packet's decision; arrivals may come on consecutive cycles, and `dec_valid` is never 1 otherwise.
- R3: The smoothed level has 8 fractional bits and updates only on arrival as level = level + floor(((qlen << 8) - level) / 2^wshift), using an arithmetic shift; its integer part (level >> 8) is what the decision uses.
- R4: With `cfg_min_th` < `cfg_max_th`, a packet whose updated integer level is below `cfg_min_th` is admitted (`dec_drop` = 0).
- R5: With `cfg_min_th` < `cfg_max_th`, a packet whose updated integer level is above `cfg_max_th` is dropped (`dec_drop` = 1).
- R6: With `cfg_min_th` < `cfg_max_th` and the level L between the thresholds inclusive, p = (L - `cfg_min_th`) * `cfg_recip`, saturated to 65535; the packet is dropped when the random value r satisfies r <= p. At L = `cfg_min_th` the packet is always admitted.
- R7: The random value is a 16-bit Galois LFSR (shift right, XOR 16'hB400 when the bit shifted out is 1, polynomial x^16+x^14+x^13+x^11+1), never 0, that advances exactly once per decision in every zone; the value before the advance is the one compared.
- R8: With `cfg_min_th` >= `cfg_max_th`, a packet is dropped exactly when its integer level is above `cfg_max_th`, and admitted otherwise.
- R9: A burst whose instantaneous length exceeds `cfg_max_th` is admitted while the smoothed level is still below `cfg_min_th`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 1 | Packet-arrival strobe, one cycle per packet |
| arr_qlen | input | 16 | Instantaneous queue length sampled with the arrival |
| cfg_min_th | input | 16 | Lower threshold, integer queue units |
| cfg_max_th | input | 16 | Upper threshold, integer queue units |
| cfg_recip | input | 16 | Reciprocal of the span, about 65536 / (max - min) |
| cfg_wshift | input | 4 | Smoothing shift, weight 2^-wshift |
| dec_valid | output | 1 | Decision strobe |
| dec_drop | output | 1 | 1 drop, 0 admit; valid with `dec_valid` |

## Verification
Every decision is due in the second cycle after the cycle in which its arrival strobe was driven: the level and zone are registered at the first edge and the decision at the next. The driver computes the expected decision from its own level and LFSR model at the moment of the arrival and records the cycle number plus two as the due time. The monitor, sampling on the falling edge, compares each strobe against the oldest expected item and its due cycle, and flags any strobe with no pending item and any item that goes past its due cycle.

// File: rtl/red_pkg.sv
package red_pkg;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;

    typedef enum logic [1:0] {
        ZONE_PASS = 2'd0,
        ZONE_RAMP = 2'd1,
        ZONE_CUT  = 2'd2
    } zone_e;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        if (s[0]) return (s >> 1) ^ LFSR_TAPS;
        return s >> 1;
    endfunction

endpackage

// File: rtl/red_avg_filter.sv
module red_avg_filter #(
    parameter int QW = 16,
    parameter int FW = 8,
    parameter int SW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [QW-1:0]    qlen,
    input  logic [SW-1:0]    wshift,
    output logic [QW+FW-1:0] avg_q,
    output logic [QW+FW-1:0] avg_nx
);
    localparam int AW = QW + FW;

    typedef struct packed {
        logic [AW-1:0] avg;
    } avg_st_t;

    avg_st_t           st_d, st_q;
    logic signed [AW:0] diff;
    logic signed [AW:0] step;

    always_comb begin
        st_d = st_q;
        diff = $signed({1'b0, qlen, {FW{1'b0}}}) - $signed({1'b0, st_q.avg});
        step = diff >>> wshift;
        if (upd) begin
            st_d.avg = st_q.avg + step[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg_q  = st_q.avg;
    assign avg_nx = st_d.avg;

endmodule

// File: rtl/red_zone_prob.sv
module red_zone_prob
    import red_pkg::*;
#(
    parameter int QW = 16,
    parameter int FW = 8,
    parameter int RW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [QW+FW-1:0] avg_in,
    input  logic [QW-1:0]    min_th,
    input  logic [QW-1:0]    max_th,
    input  logic [RW-1:0]    recip,
    output logic             out_valid,
    output zone_e            zone,
    output logic [RW-1:0]    prob
);
    localparam int AW = QW + FW;
    localparam int PW = QW + RW;

    typedef struct packed {
        logic          vld;
        zone_e         zone;
        logic [RW-1:0] prob;
    } zp_st_t;

    zp_st_t        st_d, st_q;
    logic [QW-1:0] lvl;
    logic [QW-1:0] excess;
    logic [PW-1:0] product;
    logic [RW-1:0] prob_sat;
    logic          cfg_ok;
    zone_e         zone_c;

    always_comb begin
        lvl     = avg_in[AW-1:FW];
        cfg_ok  = (min_th < max_th);
        excess  = lvl - min_th;
        product = {{RW{1'b0}}, excess} * {{QW{1'b0}}, recip};
        if (|product[PW-1:RW]) prob_sat = '1;
        else                   prob_sat = product[RW-1:0];

        if (!cfg_ok)             zone_c = (lvl > max_th) ? ZONE_CUT : ZONE_PASS;
        else if (lvl < min_th)   zone_c = ZONE_PASS;
        else if (lvl > max_th)   zone_c = ZONE_CUT;
        else                     zone_c = ZONE_RAMP;

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.zone = zone_c;
            st_d.prob = (zone_c == ZONE_RAMP) ? prob_sat : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{vld: 1'b0, zone: ZONE_PASS, prob: '0};
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign zone      = st_q.zone;
    assign prob      = st_q.prob;

endmodule

// File: rtl/red_lfsr.sv
module red_lfsr
    import red_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] value
);
    typedef struct packed {
        logic [LFSR_W-1:0] state;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) st_d.state = lfsr_next(st_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: SEED};
        else        st_q <= st_d;
    end

    assign value = st_q.state;

endmodule

// File: rtl/red_drop_unit.sv
module red_drop_unit
    import red_pkg::*;
#(
    parameter int                QW   = 16,
    parameter int                FW   = 8,
    parameter int                SW   = 4,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arr_valid,
    input  logic [QW-1:0] arr_qlen,
    input  logic [QW-1:0] cfg_min_th,
    input  logic [QW-1:0] cfg_max_th,
    input  logic [15:0]   cfg_recip,
    input  logic [SW-1:0] cfg_wshift,
    output logic          dec_valid,
    output logic          dec_drop
);
    localparam int RW = LFSR_W;
    localparam int AW = QW + FW;

    typedef struct packed {
        logic vld;
        logic drop;
    } dec_st_t;

    logic [AW-1:0] avg_lvl;
    logic [AW-1:0] avg_nx;
    logic          zp_valid;
    zone_e         zp_zone;
    logic [RW-1:0] zp_prob;
    logic [RW-1:0] rnd;
    dec_st_t       st_d, st_q;

    red_avg_filter #(.QW(QW), .FW(FW), .SW(SW)) i_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (arr_valid),
        .qlen   (arr_qlen),
        .wshift (cfg_wshift),
        .avg_q  (avg_lvl),
        .avg_nx (avg_nx)
    );

    red_zone_prob #(.QW(QW), .FW(FW), .RW(RW)) i_zone (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (arr_valid),
        .avg_in    (avg_nx),
        .min_th    (cfg_min_th),
        .max_th    (cfg_max_th),
        .recip     (cfg_recip),
        .out_valid (zp_valid),
        .zone      (zp_zone),
        .prob      (zp_prob)
    );

    red_lfsr #(.SEED(SEED)) i_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (zp_valid),
        .value (rnd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = zp_valid;
        st_d.drop = 1'b0;
        if (zp_valid) begin
            unique case (zp_zone)
                ZONE_CUT:  st_d.drop = 1'b1;
                ZONE_RAMP: st_d.drop = (rnd <= zp_prob);
                default:   st_d.drop = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_valid = st_q.vld;
    assign dec_drop  = st_q.drop;

endmodule

// File: rtl/red_drop_unit_chk.sv
module red_drop_unit_chk #(
    parameter int QW = 16,
    parameter int FW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arr_valid,
    input logic [QW-1:0]    arr_qlen,
    input logic [QW-1:0]    cfg_min_th,
    input logic [QW-1:0]    cfg_max_th,
    input logic             dec_valid,
    input logic             dec_drop,
    input logic [QW+FW-1:0] avg_lvl,
    input logic [15:0]      lfsr_val
);
    localparam int AW = QW + FW;

    logic [QW-1:0] lvl_int;
    logic [AW-1:0] q_scaled;
    logic          cfg_ok;
    assign lvl_int  = avg_lvl[AW-1:FW];
    assign q_scaled = {arr_qlen, {FW{1'b0}}};
    assign cfg_ok   = (cfg_min_th < cfg_max_th);

    // R2
    a_r2_due_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |-> ##2 dec_valid);
    a_r2_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(arr_valid, 2));
    // R3
    a_r3_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && q_scaled >= avg_lvl) |=> (avg_lvl >= $past(avg_lvl)));
    a_r3_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && q_scaled <= avg_lvl) |=> (avg_lvl <= $past(avg_lvl)));
    a_r3_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid |=> $stable(avg_lvl));
    // R4
    a_r4_low_admits: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_ok) && $past(lvl_int) < $past(cfg_min_th)) |-> !dec_drop);
    // R5
    a_r5_high_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_ok) && $past(lvl_int) > $past(cfg_max_th)) |-> dec_drop);
    // R6
    a_r6_floor_admits: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(cfg_ok) && $past(lvl_int) == $past(cfg_min_th)) |-> !dec_drop);
    // R7
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_val != 16'h0000);
    // R8
    a_r8_tail_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(cfg_ok) && $past(lvl_int) > $past(cfg_max_th)) |-> dec_drop);
    a_r8_tail_admits: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(cfg_ok) && $past(lvl_int) <= $past(cfg_max_th)) |-> !dec_drop);

endmodule

bind red_drop_unit red_drop_unit_chk #(.QW(QW), .FW(FW)) i_red_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_valid  (arr_valid),
    .arr_qlen   (arr_qlen),
    .cfg_min_th (cfg_min_th),
    .cfg_max_th (cfg_max_th),
    .dec_valid  (dec_valid),
    .dec_drop   (dec_drop),
    .avg_lvl    (avg_lvl),
    .lfsr_val   (rnd)
);

// File: tb/test_red_drop_unit.sv
module test_red_drop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arr_valid = 1'b0;
    logic [15:0] arr_qlen = '0;
    logic [15:0] cfg_min_th = 16'd100;
    logic [15:0] cfg_max_th = 16'd200;
    logic [15:0] cfg_recip = 16'd655;
    logic [3:0]  cfg_wshift = 4'd0;
    logic        dec_valid;
    logic        dec_drop;

    red_drop_unit i_red_drop_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .arr_valid  (arr_valid),
        .arr_qlen   (arr_qlen),
        .cfg_min_th (cfg_min_th),
        .cfg_max_th (cfg_max_th),
        .cfg_recip  (cfg_recip),
        .cfg_wshift (cfg_wshift),
        .dec_valid  (dec_valid),
        .dec_drop   (dec_drop)
    );

    always #4 clk = ~clk;

    typedef struct {
        bit    drop;
        int    due;
        string tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    longint      m_avg = 0;
    logic [15:0] m_lfsr = 16'hACE1;

    always @(posedge clk) cyc++;

    function automatic logic [15:0] adv(input logic [15:0] s);
        logic [15:0] n;
        n = {1'b0, s[15:1]};
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: pops expected decisions as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (dec_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "decision strobe without arrival", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.due, "R2", "decision cycle", cyc, e.due);
                    check(dec_drop == e.drop, e.tag, "drop decision", dec_drop, e.drop);
                end
            end
            if (sb.size() > 0 && sb[0].due < cyc) begin
                check(1'b0, "R2", "decision missing at due cycle", cyc, sb[0].due);
                void'(sb.pop_front());
            end
        end
    end

    // Driver: called at a falling edge, returns at the next falling edge
    task automatic arrive(input int q, input string tag);
        exp_t   e;
        longint d, lvl, p, mn, mx;
        logic [15:0] r;
        mn = longint'(cfg_min_th);
        mx = longint'(cfg_max_th);
        d = (longint'(q) <<< 8) - m_avg;
        m_avg = m_avg + (d >>> cfg_wshift);
        lvl = m_avg >>> 8;
        r = m_lfsr;
        m_lfsr = adv(m_lfsr);
        if (mn >= mx)      e.drop = (lvl > mx);
        else if (lvl < mn) e.drop = 1'b0;
        else if (lvl > mx) e.drop = 1'b1;
        else begin
            p = (lvl - mn) * longint'(cfg_recip);
            if (p > 65535) p = 65535;
            e.drop = (longint'(r) <= p);
        end
        e.due = cyc + 2;
        e.tag = tag;
        sb.push_back(e);
        arr_valid = 1'b1;
        arr_qlen  = q[15:0];
        @(negedge clk);
        arr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        idle(4);
        rst_n = 1'b0;
        idle(3);
        check(dec_valid == 1'b0, "R1", "dec_valid in reset", dec_valid, 0);
        check(dec_drop == 1'b0, "R1", "dec_drop in reset", dec_drop, 0);
        m_avg  = 0;
        m_lfsr = 16'hACE1;
        rst_n  = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        idle(2);
        do_reset();

        // R4: below lower threshold, level equals length with wshift 0
        arrive(0, "R4");
        arrive(50, "R4");
        arrive(99, "R4");
        idle(2);
        // R5: above upper threshold
        arrive(201, "R5");
        arrive(1000, "R5");
        arrive(65535, "R5");
        idle(3);
        // R6: ramp zone including both ends
        arrive(100, "R6");
        for (int i = 0; i < 8; i++) arrive(150, "R6");
        arrive(200, "R6");
        for (int i = 0; i < 8; i++) arrive(185, "R6");
        arrive(100, "R6");
        idle(3);
        // R7: sequence advances on every decision, in every zone
        for (int i = 0; i < 30; i++) begin
            arrive(150, "R7");
            arrive((i % 2 == 0) ? 40 : 300, "R7");
        end
        idle(3);
        // R3: smoothing with wshift 2, rising and falling
        cfg_wshift = 4'd2;
        for (int i = 0; i < 6; i++) arrive(400, "R3");
        idle(2);
        for (int i = 0; i < 10; i++) arrive(20, "R3");
        for (int i = 0; i < 6; i++) arrive(170, "R3");
        idle(3);
        // R8: thresholds out of order, then equal
        cfg_wshift = 4'd0;
        cfg_min_th = 16'd300;
        cfg_max_th = 16'd200;
        idle(1);
        arrive(150, "R8");
        arrive(200, "R8");
        arrive(201, "R8");
        arrive(250, "R8");
        idle(3);
        cfg_min_th = 16'd200;
        idle(1);
        arrive(199, "R8");
        arrive(200, "R8");
        arrive(210, "R8");
        idle(3);
        // R9 and R1: fresh reset, level starts from zero, burst absorbed
        cfg_min_th = 16'd200;
        cfg_max_th = 16'd400;
        cfg_recip  = 16'd327;
        cfg_wshift = 4'd3;
        do_reset();
        arrive(1000, "R9");
        arrive(1000, "R9");
        for (int i = 0; i < 10; i++) arrive(1000, "R9");
        idle(6);
        check(sb.size() == 0, "R2", "decisions outstanding at end", sb.size(), 0);
        finish_run();
    end

endmodule